// File: doc/BRIEF.md
# Multi-Core Heartbeat Lockup Monitor

This block decides, once per check interval, whether a group of processor cores are all still alive, and only then refreshes a downstream watchdog. Each core raises a one-cycle heartbeat pulse from its periodic timer interrupt. The pulse sets a sticky per-core flag. A check timer counts enabled clock cycles and runs a check at the end of every interval. The check scans the flags of the cores that take part, clears them as it goes, and sends a one-cycle kick to the watchdog only if every participant had checked in. A single stalled core is enough to withhold the kick, so the watchdog expires and reports the lockup.

One core, chosen by a parameter, is the supervising core. It always takes part, and its flag is examined before any other. If the supervising core has not checked in, the check ends at once with no effect. The other cores are then visited from index 0 upwards, and only those set in the online mask are examined. The first online core with a clear flag ends the pass. Flags already cleared in that pass stay cleared, and flags later in the scan are left untouched. The check interval is a parameter in clock cycles. The watchdog that receives the kick is outside this block.

Top module: `hb_lockup_monitor`

## Requirements
- R1: A heartbeat pulse on core i sets that core's flag at the next clock edge, and the flag stays set until a check clears it, whatever the online mask holds.
- R2: While enabled, a check runs in every CHECK_PERIOD-th enabled cycle, counting from the first enabled cycle. A kick is kick_o high for exactly one cycle, in the cycle after the check.
- R3: If the supervising core (index HOST_CORE) has a clear flag at a check, no kick is issued and no flag is cleared.
- R4: Once the supervising core's flag is seen set and cleared, the online cores other than the supervisor are visited in ascending index order. Each set flag is cleared. The first online core with a clear flag ends the pass with no kick, and the flags of cores after it keep their values.
- R5: A core whose online_i bit is 0, other than the supervising core, is not examined, and a check never clears its flag.
- R6: A kick is issued only when the supervising core and every online core had their flags set at the check. All of those flags are cleared by that check.
- R7: A heartbeat arriving in the same cycle as a check that clears that core's flag wins, so the flag is set for the next check.
- R8: While enable_i is 0, the check timer is held at zero and kick_o stays 0. After enable_i rises again, the first check falls in the CHECK_PERIOD-th enabled cycle.
- R9: Reset (rst_ni low) clears all flags, the check timer and kick_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the check timer; when low, the kick is held off |
| heartbeat_i | input | NUM_CORES | One-cycle alive pulse per core |
| online_i | input | NUM_CORES | Cores that take part in the check |
| kick_o | output | 1 | One-cycle refresh pulse to the watchdog |

## Verification
A core's heartbeat and the check that clears its flag can land in the same cycle. The bench provokes this by pulsing every heartbeat in the exact cycle of a check that also issues a kick. It then runs a following interval with no heartbeats at all. A second kick at the end of that interval shows that the late heartbeat survived the clear. The abort order is judged the same way, at the kick output: after a pass that fails partway, the next interval refreshes only the cores that were cleared, and a kick must then follow only if the untouched later flags were kept.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    // Default geometry used when the top is elaborated on its own.
    localparam int unsigned DEF_CORES  = 4;
    localparam int unsigned DEF_PERIOD = 64;
    localparam int unsigned DEF_HOST   = 0;

    // Registered output state of the top level.
    typedef struct packed {
        logic kick;
    } kick_state_t;

    // Outcome of one scan over the flags.
    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_PASS  = 2'd1,
        SCAN_ABORT = 2'd2
    } scan_result_e;

endpackage

// File: rtl/hbm_timer.sv
module hbm_timer #(
    parameter int unsigned PERIOD = 64,
    localparam int unsigned CW    = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    output logic tick_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] count;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.count == LAST);
        if (!enable_i) begin
            st_d.count = '0;
        end else if (at_end) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = enable_i && at_end;

endmodule

// File: rtl/hbm_flags.sv
module hbm_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // A set in the same cycle as a clear leaves the flag set.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(N); i++) begin
            if (set_i[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flag;

endmodule

// File: rtl/hbm_scan.sv
module hbm_scan
    import hbm_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter int unsigned HOST = 0
) (
    input  logic         check_i,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] online_i,
    output logic [N-1:0] clr_o,
    output scan_result_e result_o
);

    logic         host_ok;
    logic [N:0]   blocked;   // blocked[i]: the pass ended before core i
    logic [N-1:0] miss;

    assign host_ok    = flags_i[HOST];
    assign blocked[0] = !host_ok;

    for (genvar i = 0; i < int'(N); i++) begin : g_core
        if (i == int'(HOST)) begin : g_host
            assign miss[i]    = 1'b0;
            assign clr_o[i]   = check_i && host_ok;
        end else begin : g_other
            assign miss[i]    = online_i[i] && !flags_i[i];
            assign clr_o[i]   = check_i && online_i[i] && flags_i[i]
                                && !blocked[i];
        end
        assign blocked[i+1] = blocked[i] || miss[i];
    end

    always_comb begin
        if (!check_i) begin
            result_o = SCAN_IDLE;
        end else if (blocked[N]) begin
            result_o = SCAN_ABORT;
        end else begin
            result_o = SCAN_PASS;
        end
    end

endmodule

// File: rtl/hb_lockup_monitor.sv
module hb_lockup_monitor
    import hbm_pkg::*;
#(
    parameter int unsigned NUM_CORES    = DEF_CORES,
    parameter int unsigned CHECK_PERIOD = DEF_PERIOD,
    parameter int unsigned HOST_CORE    = DEF_HOST
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 enable_i,
    input  logic [NUM_CORES-1:0] heartbeat_i,
    input  logic [NUM_CORES-1:0] online_i,
    output logic                 kick_o
);

    logic                 check_tick;
    logic [NUM_CORES-1:0] flag_vec;
    logic [NUM_CORES-1:0] clr_vec;
    scan_result_e         scan_res;
    kick_state_t          st_d, st_q;

    hbm_timer #(
        .PERIOD (CHECK_PERIOD)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .tick_o   (check_tick)
    );

    hbm_flags #(
        .N (NUM_CORES)
    ) u_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (heartbeat_i),
        .clr_i   (clr_vec),
        .flags_o (flag_vec)
    );

    hbm_scan #(
        .N    (NUM_CORES),
        .HOST (HOST_CORE)
    ) u_scan (
        .check_i  (check_tick),
        .flags_i  (flag_vec),
        .online_i (online_i),
        .clr_o    (clr_vec),
        .result_o (scan_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.kick = (scan_res == SCAN_PASS);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kick_o = st_q.kick;

endmodule

module hbm_checker #(
    parameter int unsigned N    = 4,
    parameter int unsigned HOST = 0
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         enable_i,
    input logic [N-1:0] heartbeat_i,
    input logic [N-1:0] online_i,
    input logic [N-1:0] flag_vec,
    input logic         kick_o
);

    localparam logic [N-1:0] HOST_MASK = N'(1) << HOST;

    logic [N-1:0] part_mask;
    logic [N-1:0] idle_mask;
    assign part_mask = online_i | HOST_MASK;
    assign idle_mask = flag_vec & ~part_mask;

    // R1
    hb_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (heartbeat_i != '0) |=> ((flag_vec & $past(heartbeat_i)) == $past(heartbeat_i)));

    // R2
    kick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_o |=> !kick_o);

    // R3
    host_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_vec[HOST] |=> !kick_o);

    // R5
    offline_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_mask != '0) |=> ((flag_vec & $past(idle_mask)) == $past(idle_mask)));

    // R6
    kick_all_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(kick_o) |-> ($past(flag_vec & part_mask) == $past(part_mask)));

    // R8
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !kick_o);

endmodule

bind hb_lockup_monitor hbm_checker #(
    .N    (NUM_CORES),
    .HOST (HOST_CORE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .heartbeat_i (heartbeat_i),
    .online_i    (online_i),
    .flag_vec    (flag_vec),
    .kick_o      (kick_o)
);

// File: tb/hb_lockup_monitor_tb.sv
module hb_lockup_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int PER = 16;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic          enable_i;
    logic [NC-1:0] heartbeat_i;
    logic [NC-1:0] online_i;
    logic          kick_o;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_lockup_monitor #(
        .NUM_CORES    (NC),
        .CHECK_PERIOD (PER),
        .HOST_CORE    (0)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .heartbeat_i (heartbeat_i),
        .online_i    (online_i),
        .kick_o      (kick_o)
    );

    // {online[3:0], heartbeats[3:0], expected kick}; supervisor is core 0
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        {4'b1111, 4'b1111, 1'b1},  // R6 all checked in
        {4'b1111, 4'b1110, 1'b0},  // R3 supervisor missing, nothing cleared
        {4'b1111, 4'b0001, 1'b1},  // R1 flags of cores 1-3 kept
        {4'b1111, 4'b1011, 1'b0},  // R4 abort at core 2, core 3 kept
        {4'b1111, 4'b0111, 1'b1},  // R4 core 3 survived the abort
        {4'b1111, 4'b1101, 1'b0},  // R4 abort at core 1
        {4'b1111, 4'b0011, 1'b1},  // R4 cores 2,3 survived the abort
        {4'b0101, 4'b0101, 1'b1},  // R5 offline cores 1,3 ignored
        {4'b1011, 4'b1011, 1'b1},  // R5 offline core 2 ignored
        {4'b0001, 4'b0001, 1'b1},  // R5 only supervisor online
        {4'b1111, 4'b0001, 1'b0},  // R4 abort at core 1, supervisor cleared
        {4'b1111, 4'b1110, 1'b0},  // R4 supervisor stayed cleared
        {4'b1111, 4'b0001, 1'b1},  // R1 cores 1-3 kept from earlier
        {4'b0001, 4'b1111, 1'b1},  // R5 offline flags not cleared
        {4'b1111, 4'b0001, 1'b1}   // R5 offline flags still set
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: kick_o=%b expected %b", tag, act, exp);
        end
    endtask

    // Starts on a negedge where the check counter is zero; spans PER edges.
    task automatic window(input logic [NC-1:0] onl, input logic [NC-1:0] hb,
                          input logic exp, input bit late_hb, input string tag);
        logic stray = 1'b0;
        online_i = onl;
        for (int k = 1; k <= PER; k++) begin
            @(negedge clk);
            if (k < PER && kick_o) stray = 1'b1;
            if (k == 1) heartbeat_i = hb;
            else if (k == PER - 1 && late_hb) heartbeat_i = {NC{1'b1}};
            else heartbeat_i = '0;
        end
        check(stray, 1'b0, {tag, " (R2 no early kick)"});
        check(kick_o, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        rst_ni      = 1'b0;
        enable_i    = 1'b0;
        heartbeat_i = '0;
        online_i    = '1;
        repeat (3) @(negedge clk);
        check(kick_o, 1'b0, "R9 reset state");
        rst_ni = 1'b1;

        // R8: disabled, heartbeats arrive, never a kick
        begin
            logic stray = 1'b0;
            for (int k = 0; k < PER + 4; k++) begin
                heartbeat_i = (k == 1) ? '1 : '0;
                @(negedge clk);
                if (kick_o) stray = 1'b1;
            end
            check(stray, 1'b0, "R8 disabled holds kick low");
        end

        // consume flags left from the disabled phase
        enable_i = 1'b1;
        window('1, '0, 1'b1, 1'b0, "R1 flags set while disabled kick");

        for (int v = 0; v < NV; v++) begin
            window(VEC[v][8:5], VEC[v][4:1], VEC[v][0], 1'b0,
                   $sformatf("vector %0d", v));
        end

        // R7: heartbeats in the same cycle as a clearing check
        window('1, '1, 1'b1, 1'b1, "R7 kick with late heartbeat");
        window('1, '0, 1'b1, 1'b0, "R7 late heartbeat kept");
        window('1, '0, 1'b0, 1'b0, "R2 flags consumed");

        // R8: disable partway, restart counts from zero
        heartbeat_i = '1;
        @(negedge clk);
        heartbeat_i = '0;
        repeat (4) @(negedge clk);
        enable_i = 1'b0;
        begin
            logic stray = 1'b0;
            for (int k = 0; k < PER; k++) begin
                @(negedge clk);
                if (kick_o) stray = 1'b1;
            end
            check(stray, 1'b0, "R8 no kick while disabled");
        end
        enable_i = 1'b1;
        window('1, '0, 1'b1, 1'b0, "R8 restart full period");

        // R9: reset clears flags
        heartbeat_i = '1;
        @(negedge clk);
        heartbeat_i = '0;
        rst_ni = 1'b0;
        @(negedge clk);
        check(kick_o, 1'b0, "R9 kick low in reset");
        rst_ni = 1'b1;
        window('1, '0, 1'b0, 1'b0, "R9 flags cleared by reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule